// File: doc/BRIEF.md
# Cache Request Front-End with Fast Write Allocate

This block is the processor-facing request path of a write-back data cache. A request may be presented in any cycle: a read, a write, a write-invalidate, or a writeback. Each can also be marked uncacheable. For a cacheable request the block looks up a set-associative tag array with four ways and LRU replacement. If the lookup misses, a write that covers a whole line can still be installed directly, with no fetch. Any other miss is handed to the miss-status holding register (MSHR) file through a registered miss port. The block also exposes the line address the MSHR file must compare against, and it takes back a match flag in the same cycle.

A line displaced by a direct install is pushed to the memory-side writeback port when it is dirty. This push happens one cycle before the hit or miss outcome of the request that displaced it. Hits that need a response get a response strobe after a fixed latency. Hits and misses are counted per command class. An optional limit on cacheable misses raises a terminal flag when it runs out. The data array is out of scope and is modelled only by the response latency.

Top module: `cfe_top`

## Requirements
- R1: After reset every output strobe is low, every hit and miss counter reads zero and the tag array is empty, so the first cacheable read misses.
- R2: An uncacheable request never consults or changes the tags. It always goes to the miss port with missUncache=1, missAddr equal to reqAddr, and missSize equal to reqSize. It is not counted in the miss counters or against the miss limit, and a later cacheable access to the same line sees the tags unchanged.
- R3: A cacheable write (reqCmd=1) or write-invalidate (reqCmd=2) that misses is installed directly only when all of these hold: reqSize is at least LINE_BYTES, and fastWriteEn=1. A plain write additionally needs mshrMatch=0. A write-invalidate ignores mshrMatch. Otherwise it is a miss.
- R4: A directly installed line is valid and writable, so a later read or a partial write to that line hits.
- R5: Victim choice in a set is the lowest-numbered invalid way, or if none is invalid, the least recently used way. A displaced dirty victim raises wbValid with its line address in cycle 1, where cycle 0 is the cycle the request is presented. The outcome of that request follows in cycle 2.
- R6: outValid pulses in cycle 2 with outHit=1 for a hit or direct install. respValid pulses only in cycle HIT_LAT, and only for such a request with reqNeedsResp=1.
- R7: A writeback (reqCmd=3) that hits raises outSatisfied with its outcome and marks the line dirty. No other outcome raises outSatisfied.
- R8: A write or write-invalidate with reqLock=1 raises scSet in cycle 1. Reads and writebacks never do.
- R9: A cacheable miss raises missValid in cycle 2 with missUncache=0, missCmd equal to the request command, missAddr equal to the line address (low log2(LINE_BYTES) bits cleared), and missSize equal to LINE_BYTES.
- R10: Counters are kept per class. Class 0 is read, class 1 is write and write-invalidate, class 2 is writeback, held in field c at bits [c*CNT_W +: CNT_W] of hitCount and missCount. A hit or direct install adds one to hitCount, a cacheable miss adds one to missCount, and both update in cycle 2.
- R11: With MISS_LIMIT>0, limitReached rises in cycle 2 of the MISS_LIMIT-th cacheable miss after reset and stays high.
- R12: mshrLookupAddr combinationally equals the line address of reqAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqCmd | input | 2 | 0 read, 1 write, 2 write-invalidate, 3 writeback |
| reqUncache | input | 1 | Request bypasses the cache |
| reqLock | input | 1 | Store-conditional marker |
| reqNeedsResp | input | 1 | Request expects a response |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | log2(LINE_BYTES)+1 | Access size in bytes |
| fastWriteEn | input | 1 | Permits direct install of full-line writes |
| mshrLookupAddr | output | ADDR_W | Line address for the MSHR compare |
| mshrMatch | input | 1 | An MSHR holds that line |
| wbValid | output | 1 | Victim pushed to the writeback queue |
| wbAddr | output | ADDR_W | Victim line address |
| outValid | output | 1 | Outcome strobe |
| outHit | output | 1 | Outcome was a hit or direct install |
| outSatisfied | output | 1 | Writeback satisfied by a hit |
| missValid | output | 1 | Miss handed to the MSHR file |
| missUncache | output | 1 | Miss is uncacheable |
| missCmd | output | 2 | Command of the miss |
| missAddr | output | ADDR_W | Miss address |
| missSize | output | log2(LINE_BYTES)+1 | Miss size in bytes |
| respValid | output | 1 | Hit response after HIT_LAT cycles |
| scSet | output | 1 | Conditional result set to 1 |
| hitCount | output | 3*CNT_W | Per-class hit counters |
| missCount | output | 3*CNT_W | Per-class miss counters |
| limitReached | output | 1 | Miss limit exhausted (sticky) |

## Verification
The overlap to watch is a victim push landing in the same cycle as another request's outcome. When requests arrive in consecutive cycles, the writeback of the second shares cycle 2 of the first with the first's miss outcome. The bench provokes this deliberately. It fills one set with direct installs, then issues a read miss to another set immediately followed by a write-invalidate that evicts a dirty line. In that shared cycle it checks the first request's miss fields and the second request's writeback address against a reference tag model with timestamp LRU.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_WRINV = 2'd2,
    CMD_WBACK = 2'd3
  } cmd_e;

  localparam int NCLS = 3;

  // strobes from control to the tag datapath
  typedef struct packed {
    logic touch;      // hit: refresh LRU of the hit way
    logic install;    // direct install into the victim way
    logic markDirty;  // set dirty on the updated way
  } tagStrobe_t;

  function automatic logic [1:0] cmdClass(cmd_e c);
    case (c)
      CMD_READ:  return 2'd0;
      CMD_WBACK: return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/cfe_tags.sv
module cfe_tags
  import cfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] lookupLine,
  input  tagStrobe_t                        strobe,
  output logic                              tagHit,
  output logic                              hitWritable,
  output logic                              victimDirty,
  output logic [ADDR_W-1:0]                 victimLine
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic             vld [SETS][WAYS];
  logic             wrt [SETS][WAYS];
  logic             drt [SETS][WAYS];
  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAY_W-1:0] age [SETS][WAYS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;
  logic [WAYS-1:0]  wayHit, wayFree, wayOld;
  logic [WAY_W-1:0] hitWay, victimWay, updWay, useAge;
  logic             freeFound;

  assign setIdx = lookupLine[IDX_W-1:0];
  assign tagIn  = lookupLine[IDX_W +: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w]  = vld[setIdx][w] && (tagMem[setIdx][w] == tagIn);
    assign wayFree[w] = !vld[setIdx][w];
    assign wayOld[w]  = (age[setIdx][w] == WAY_W'(WAYS-1));
  end

  always_comb begin
    hitWay    = '0;
    victimWay = '0;
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayHit[w]) hitWay = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!freeFound && wayFree[w]) begin
        victimWay = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wayOld[w]) victimWay = WAY_W'(w);
      end
    end
  end

  assign tagHit      = |wayHit;
  assign hitWritable = wrt[setIdx][hitWay];
  assign victimDirty = vld[setIdx][victimWay] && drt[setIdx][victimWay];
  assign victimLine  = {tagMem[setIdx][victimWay], setIdx, {OFF_W{1'b0}}};

  assign updWay = strobe.install ? victimWay : hitWay;
  assign useAge = age[setIdx][updWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]    <= 1'b0;
          wrt[s][w]    <= 1'b0;
          drt[s][w]    <= 1'b0;
          tagMem[s][w] <= '0;
          age[s][w]    <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.install) begin
        vld[setIdx][updWay]    <= 1'b1;
        wrt[setIdx][updWay]    <= 1'b1;
        drt[setIdx][updWay]    <= strobe.markDirty;
        tagMem[setIdx][updWay] <= tagIn;
      end else if (strobe.markDirty) begin
        drt[setIdx][updWay] <= 1'b1;
      end
      if (strobe.touch || strobe.install) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == updWay)         age[setIdx][w] <= '0;
          else if (age[setIdx][w] < useAge) age[setIdx][w] <= age[setIdx][w] + 1'b1;
        end
      end
    end
  end

  // R5: control never asks for both a refresh and an install at once
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.touch, strobe.install}));

  // R3: a direct install is only requested when the lookup missed
  p_install_on_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |-> !tagHit);

  // R4: a refresh is only requested for a line that is present
  p_touch_on_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.touch |-> tagHit);

endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int HIT_LAT    = 3,
  parameter int CNT_W      = 16,
  parameter int MISS_LIMIT = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  cmd_e                          reqCmd,
  input  logic                          reqUncache,
  input  logic                          reqLock,
  input  logic                          reqNeedsResp,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [$clog2(LINE_BYTES):0]   reqSize,
  input  logic                          fastWriteEn,
  input  logic                          mshrMatch,
  input  logic                          tagHit,
  input  logic                          hitWritable,
  input  logic                          victimDirty,
  input  logic [ADDR_W-1:0]             victimLine,
  output tagStrobe_t                    strobe,
  output logic [ADDR_W-1:0]             lineAddr,
  output logic                          wbValid,
  output logic [ADDR_W-1:0]             wbAddr,
  output logic                          outValid,
  output logic                          outHit,
  output logic                          outSatisfied,
  output logic                          missValid,
  output logic                          missUncache,
  output logic [1:0]                    missCmd,
  output logic [ADDR_W-1:0]             missAddr,
  output logic [$clog2(LINE_BYTES):0]   missSize,
  output logic                          respValid,
  output logic                          scSet,
  output logic [NCLS*CNT_W-1:0]         hitCount,
  output logic [NCLS*CNT_W-1:0]         missCount,
  output logic                          limitReached
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SIZE_W = OFF_W + 1;
  localparam int LIM_W  = (MISS_LIMIT > 0) ? $clog2(MISS_LIMIT + 1) : 1;

  logic isWrCls, cacheable, hitNow, fullLine, fastNow, served;

  assign lineAddr  = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign isWrCls   = (reqCmd == CMD_WRITE) || (reqCmd == CMD_WRINV);
  assign cacheable = reqValid && !reqUncache;
  assign hitNow    = cacheable && tagHit && (!isWrCls || hitWritable);
  assign fullLine  = reqSize >= SIZE_W'(LINE_BYTES);
  assign fastNow   = cacheable && !tagHit && fastWriteEn && isWrCls && fullLine &&
                     ((reqCmd == CMD_WRINV) || !mshrMatch);
  assign served    = hitNow || fastNow;

  always_comb begin
    strobe.touch     = hitNow;
    strobe.install   = fastNow;
    strobe.markDirty = fastNow || (hitNow && reqCmd != CMD_READ);
  end

  // stage 1: victim push, conditional result, captured outcome
  logic              s1Valid, s1Served, s1Unc, s1Sat;
  logic [1:0]        s1Cls, s1Cmd;
  logic [ADDR_W-1:0] s1Addr;
  logic [SIZE_W-1:0] s1Size;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0; s1Served <= 1'b0; s1Unc <= 1'b0; s1Sat <= 1'b0;
      s1Cls   <= '0;   s1Cmd    <= '0;   s1Addr <= '0;  s1Size <= '0;
      wbValid <= 1'b0; wbAddr   <= '0;   scSet  <= 1'b0;
    end else begin
      s1Valid  <= reqValid;
      s1Served <= served;
      s1Unc    <= reqUncache;
      s1Sat    <= reqCmd == CMD_WBACK;
      s1Cls    <= cmdClass(reqCmd);
      s1Cmd    <= reqCmd;
      s1Addr   <= reqUncache ? reqAddr : lineAddr;
      s1Size   <= reqUncache ? reqSize : SIZE_W'(LINE_BYTES);
      wbValid  <= fastNow && victimDirty;
      wbAddr   <= victimLine;
      scSet    <= reqValid && reqLock && isWrCls;
    end
  end

  // stage 2: outcome and miss hand-off
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outHit <= 1'b0; outSatisfied <= 1'b0;
      missValid <= 1'b0; missUncache <= 1'b0; missCmd <= '0;
      missAddr <= '0; missSize <= '0;
    end else begin
      outValid     <= s1Valid;
      outHit       <= s1Valid && s1Served;
      outSatisfied <= s1Valid && s1Served && s1Sat;
      missValid    <= s1Valid && !s1Served;
      missUncache  <= s1Unc;
      missCmd      <= s1Cmd;
      missAddr     <= s1Addr;
      missSize     <= s1Size;
    end
  end

  // per-class counters
  for (genvar c = 0; c < NCLS; c++) begin : g_cnt
    logic [CNT_W-1:0] hc, mc;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hc <= '0;
        mc <= '0;
      end else if (s1Valid && s1Cls == 2'(c)) begin
        if (s1Served)    hc <= hc + 1'b1;
        else if (!s1Unc) mc <= mc + 1'b1;
      end
    end
    assign hitCount[c*CNT_W +: CNT_W]  = hc;
    assign missCount[c*CNT_W +: CNT_W] = mc;
  end

  // optional miss limit
  if (MISS_LIMIT > 0) begin : g_lim
    logic [LIM_W-1:0] left;
    logic             reached;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        left    <= LIM_W'(MISS_LIMIT);
        reached <= 1'b0;
      end else if (s1Valid && !s1Served && !s1Unc && left != '0) begin
        left <= left - 1'b1;
        if (left == LIM_W'(1)) reached <= 1'b1;
      end
    end
    assign limitReached = reached;
  end else begin : g_nolim
    assign limitReached = 1'b0;
  end

  // hit response delay line
  logic [HIT_LAT-1:0] respPipe;
  always_ff @(posedge clk) begin
    if (!rstN) respPipe <= '0;
    else       respPipe <= {respPipe[HIT_LAT-2:0], reqValid && served && reqNeedsResp};
  end
  assign respValid = respPipe[HIT_LAT-1];

  // R5: a victim push is followed by the hit outcome of its request
  p_wb_then_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> (outValid && outHit));

  // R9: a miss hand-off always accompanies a non-hit outcome
  p_miss_not_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> (outValid && !outHit));

  // R9: cacheable misses are line aligned
  p_miss_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !missUncache) |-> (missAddr[OFF_W-1:0] == '0));

  // R7: satisfied only comes with a hit outcome
  p_sat_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    outSatisfied |-> outHit);

  // R11: limit flag never drops
  p_limit_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    limitReached |=> limitReached);

  // R8: conditional result only for accepted write-class requests
  p_sc_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    scSet |-> s1Valid);

endmodule

// File: rtl/cfe_top.sv
module cfe_top
  import cfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int HIT_LAT    = 3,
  parameter int CNT_W      = 16,
  parameter int MISS_LIMIT = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqCmd,
  input  logic                        reqUncache,
  input  logic                        reqLock,
  input  logic                        reqNeedsResp,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [$clog2(LINE_BYTES):0] reqSize,
  input  logic                        fastWriteEn,
  output logic [ADDR_W-1:0]           mshrLookupAddr,
  input  logic                        mshrMatch,
  output logic                        wbValid,
  output logic [ADDR_W-1:0]           wbAddr,
  output logic                        outValid,
  output logic                        outHit,
  output logic                        outSatisfied,
  output logic                        missValid,
  output logic                        missUncache,
  output logic [1:0]                  missCmd,
  output logic [ADDR_W-1:0]           missAddr,
  output logic [$clog2(LINE_BYTES):0] missSize,
  output logic                        respValid,
  output logic                        scSet,
  output logic [3*CNT_W-1:0]          hitCount,
  output logic [3*CNT_W-1:0]          missCount,
  output logic                        limitReached
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  tagStrobe_t        strobe;
  logic              tagHit, hitWritable, victimDirty;
  logic [ADDR_W-1:0] victimLine, lineAddr;

  assign mshrLookupAddr = lineAddr;

  cfe_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .HIT_LAT(HIT_LAT),
    .CNT_W(CNT_W), .MISS_LIMIT(MISS_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqCmd(cmd_e'(reqCmd)), .reqUncache(reqUncache),
    .reqLock(reqLock), .reqNeedsResp(reqNeedsResp), .reqAddr(reqAddr),
    .reqSize(reqSize), .fastWriteEn(fastWriteEn), .mshrMatch(mshrMatch),
    .tagHit(tagHit), .hitWritable(hitWritable), .victimDirty(victimDirty),
    .victimLine(victimLine), .strobe(strobe), .lineAddr(lineAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .outValid(outValid), .outHit(outHit),
    .outSatisfied(outSatisfied), .missValid(missValid), .missUncache(missUncache),
    .missCmd(missCmd), .missAddr(missAddr), .missSize(missSize),
    .respValid(respValid), .scSet(scSet), .hitCount(hitCount),
    .missCount(missCount), .limitReached(limitReached)
  );

  cfe_tags #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS)
  ) tags_i (
    .clk(clk), .rstN(rstN),
    .lookupLine(reqAddr[ADDR_W-1:OFF_W]), .strobe(strobe),
    .tagHit(tagHit), .hitWritable(hitWritable),
    .victimDirty(victimDirty), .victimLine(victimLine)
  );

endmodule

// File: tb/cfe_top_tb_top.sv
`timescale 1ns/1ps
module cfe_top_tb_top;
  localparam int ADDR_W = 32;
  localparam int LINE   = 64;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;
  localparam int HLAT   = 3;
  localparam int CW     = 16;
  localparam int LIMIT  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqUncache = 0, reqLock = 0, reqNeedsResp = 0;
  logic [1:0] reqCmd = 0;
  logic [ADDR_W-1:0] reqAddr = 0;
  logic [6:0] reqSize = 0;
  logic fastWriteEn = 0, mshrMatch = 0;
  logic [ADDR_W-1:0] mshrLookupAddr, wbAddr, missAddr;
  logic wbValid, outValid, outHit, outSatisfied, missValid, missUncache, respValid, scSet, limitReached;
  logic [1:0] missCmd;
  logic [6:0] missSize;
  logic [3*CW-1:0] hitCount, missCount;

  always #10 clk = ~clk;

  cfe_top #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .SETS(SETS), .WAYS(WAYS),
            .HIT_LAT(HLAT), .CNT_W(CW), .MISS_LIMIT(LIMIT)) dut_i (.*);

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: timestamp LRU
  bit mV[SETS*WAYS];
  bit mD[SETS*WAYS];
  int mT[SETS*WAYS];
  int mS[SETS*WAYS];
  int stampCtr = 0;
  int eHitC[3], eMissC[3];
  int eMissTot = 0;

  typedef struct {
    bit hit; bit wb; logic [31:0] wbA; bit sat; bit miss; bit resp; bit sc;
    logic [31:0] mA; int mSz; bit mUnc; int cmd;
  } exp_t;

  function automatic int clsOf(int cmd);
    return (cmd == 0) ? 0 : (cmd == 3) ? 2 : 1;
  endfunction

  task automatic modelStep(int cmd, bit unc, bit lock, bit need, logic [31:0] a,
                           int size, bit fwe, bit mm, output exp_t e);
    int st, tg, h, v;
    st = int'((a >> 6) & 32'hF);
    tg = int'(a >> 10);
    e = '{default: 0};
    e.cmd = cmd; e.mUnc = unc;
    e.sc = lock && (cmd == 1 || cmd == 2);
    if (unc) begin
      e.miss = 1; e.mA = a; e.mSz = size;
    end else begin
      h = -1;
      for (int w = 0; w < WAYS; w++) if (mV[st*WAYS+w] && mT[st*WAYS+w] == tg) h = w;
      if (h >= 0) begin
        e.hit = 1;
        mS[st*WAYS+h] = ++stampCtr;
        if (cmd != 0) mD[st*WAYS+h] = 1;
      end else if (fwe && (cmd == 1 || cmd == 2) && size >= LINE && (cmd == 2 || !mm)) begin
        v = -1;
        for (int w = 0; w < WAYS; w++) if (v < 0 && !mV[st*WAYS+w]) v = w;
        if (v < 0) begin
          v = 0;
          for (int w = 1; w < WAYS; w++) if (mS[st*WAYS+w] < mS[st*WAYS+v]) v = w;
        end
        if (mV[st*WAYS+v] && mD[st*WAYS+v]) begin
          e.wb = 1;
          e.wbA = (32'(mT[st*WAYS+v]) << 10) | (32'(st) << 6);
        end
        mV[st*WAYS+v] = 1; mD[st*WAYS+v] = 1; mT[st*WAYS+v] = tg;
        mS[st*WAYS+v] = ++stampCtr;
        e.hit = 1;
      end else begin
        e.miss = 1; e.mA = a & ~32'h3F; e.mSz = LINE;
      end
      if (e.hit) eHitC[clsOf(cmd)]++;
      else begin eMissC[clsOf(cmd)]++; eMissTot++; end
    end
    e.resp = e.hit && need;
    e.sat  = e.hit && cmd == 3;
  endtask

  task automatic drive(int cmd, bit unc, bit lock, bit need, logic [31:0] a, int size, bit fwe, bit mm);
    reqValid = 1; reqCmd = 2'(cmd); reqUncache = unc; reqLock = lock; reqNeedsResp = need;
    reqAddr = a; reqSize = 7'(size); fastWriteEn = fwe; mshrMatch = mm;
  endtask

  task automatic chkStage1(exp_t e);
    chk("R5 wbValid", wbValid, e.wb);
    if (e.wb) chk("R5 wbAddr", wbAddr, e.wbA);
    chk("R8 scSet", scSet, e.sc);
  endtask

  task automatic chkStage2(exp_t e);
    chk("R6 outValid", outValid, 1);
    chk("R3/R4/R6 outHit", outHit, e.hit);
    chk("R7 outSatisfied", outSatisfied, e.sat);
    chk("R9 missValid", missValid, e.miss);
    if (e.miss) begin
      chk("R2/R9 missUncache", missUncache, e.mUnc);
      chk("R2/R9 missAddr", missAddr, e.mA);
      chk("R2/R9 missSize", missSize, e.mSz);
      chk("R9 missCmd", missCmd, e.cmd);
    end
  endtask

  task automatic chkCounters();
    for (int c = 0; c < 3; c++) begin
      chk("R10 hitCount", hitCount[c*CW +: CW], eHitC[c]);
      chk("R10 missCount", missCount[c*CW +: CW], eMissC[c]);
    end
    chk("R11 limitReached", limitReached, eMissTot >= LIMIT);
  endtask

  task automatic doReq(int cmd, bit unc, bit lock, bit need, logic [31:0] a, int size, bit fwe, bit mm);
    exp_t e;
    @(negedge clk);
    drive(cmd, unc, lock, need, a, size, fwe, mm);
    modelStep(cmd, unc, lock, need, a, size, fwe, mm, e);
    #1 chk("R12 mshrLookupAddr", mshrLookupAddr, a & ~32'h3F);
    @(negedge clk);
    reqValid = 0;
    chkStage1(e);
    @(negedge clk);
    chkStage2(e);
    chkCounters();
    chk("R6 respValid early", respValid, 0);
    for (int i = 2; i < HLAT; i++) @(negedge clk);
    chk("R6 respValid", respValid, e.resp);
  endtask

  function automatic logic [31:0] mk(int tg, int st, int off);
    return (32'(tg) << 10) | (32'(st) << 6) | 32'(off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    exp_t ea, eb;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wbValid", wbValid, 0);
    chk("R1 outValid", outValid, 0);
    chk("R1 missValid", missValid, 0);
    chk("R1 respValid", respValid, 0);
    chk("R1 scSet", scSet, 0);
    chk("R1 limitReached", limitReached, 0);
    chk("R1 hitCount", hitCount, 0);
    chk("R1 missCount", missCount, 0);
    doReq(0, 0, 0, 1, mk(1, 2, 8), 8, 1, 0);          // R1 empty: read misses
    doReq(1, 0, 0, 1, mk(1, 2, 0), 64, 1, 1);         // R3 write with MSHR match: miss
    doReq(2, 0, 0, 1, mk(1, 2, 0), 64, 1, 1);         // R3 write-invalidate ignores match
    doReq(0, 0, 0, 1, mk(1, 2, 16), 8, 1, 0);         // R4 read hits
    doReq(1, 0, 1, 1, mk(1, 2, 4), 4, 1, 0);          // R4 partial write hits, R8 lock
    doReq(0, 0, 1, 0, mk(1, 2, 4), 4, 1, 0);          // R8 locked read: no sc; R6 no resp
    doReq(0, 1, 0, 1, mk(1, 2, 12), 4, 1, 0);         // R2 uncacheable bypass
    doReq(0, 0, 0, 1, mk(1, 2, 12), 4, 1, 0);         // R2 tags unchanged: still hits
    doReq(1, 0, 0, 1, mk(3, 2, 0), 64, 0, 0);         // R3 fast writes disabled
    doReq(1, 0, 0, 1, mk(3, 2, 0), 32, 1, 0);         // R3 short write misses
    doReq(3, 0, 0, 0, mk(1, 2, 0), 64, 1, 0);         // R7 writeback hit satisfied
    doReq(3, 0, 0, 0, mk(9, 2, 0), 64, 1, 0);         // R7 writeback miss
    // R5 fill set 2 and evict by LRU
    for (int t = 4; t < 8; t++) doReq(1, 0, 0, 0, mk(t, 2, 0), 64, 1, 0);
    doReq(0, 0, 0, 1, mk(5, 2, 0), 8, 1, 0);
    doReq(2, 0, 0, 1, mk(11, 2, 0), 64, 1, 1);
    // overlap: miss outcome of A shares a cycle with B's victim push
    for (int t = 0; t < 4; t++) doReq(2, 0, 0, 0, mk(t + 20, 5, 0), 64, 1, 0);
    @(negedge clk);
    drive(0, 0, 0, 1, mk(30, 3, 0), 8, 1, 0);
    modelStep(0, 0, 0, 1, mk(30, 3, 0), 8, 1, 0, ea);
    @(negedge clk);
    chkStage1(ea);
    drive(2, 0, 0, 1, mk(31, 5, 0), 64, 1, 1);
    modelStep(2, 0, 0, 1, mk(31, 5, 0), 64, 1, 1, eb);
    @(negedge clk);
    reqValid = 0;
    chkStage2(ea);
    chkStage1(eb);
    @(negedge clk);
    chkStage2(eb);
    chkCounters();
    chk("R6 respValid A", respValid, ea.resp);
    @(negedge clk);
    chk("R6 respValid B", respValid, eb.resp);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int cmd, sz, r;
      cmd = int'($urandom_range(0, 3));
      r = int'($urandom_range(0, 3));
      sz = (r == 0) ? 1 : (r == 1) ? 8 : (r == 2) ? 32 : 64;
      doReq(cmd, $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
            mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 1)), int'($urandom_range(0, 63))),
            sz, $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule